// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Flags

This block merges three reset requests into a single active-low system reset for the core, the peripherals and the pad logic. The requests are an active-low external reset pin, a power-fail (brown-out) level and a one-cycle watchdog timeout pulse. The pin and the power-fail level take hold of the reset without waiting for a clock. Their release passes through a two-flop synchronizer. The system reset then stays low for a fixed stretch of cycles after the last source has gone quiet.

The controller keeps one sticky cause flag per source, so firmware can tell why the device restarted. A write-one-to-clear port clears these flags. The system reset does not clear them. While any request is active, and for as long as the system reset is low, every pad group is forced to a fixed safe level. This keeps the flash write-protect line low and the flash chip enable inactive. The controller also supplies the address where the core starts fetching after reset.

Top module: `rstctl_top`

## Requirements
- R1: `sys_rst_n_o` goes low when `ext_rst_n_i` is 0, when `pwr_fail_i` is 1, or after a clock edge that samples `wdt_timeout_i` at 1. The pin and the power-fail level act without a clock edge.
- R2: After the pin and power-fail requests go inactive between two edges, `sys_rst_n_o` stays low through the 17th rising edge that follows and goes high on the 18th. That is two synchronizer edges plus a 16-cycle hold.
- R3: A watchdog pulse sampled on edge E holds `sys_rst_n_o` low after edges E to E+15 and releases it on edge E+16.
- R4: A new request during the hold restarts the full 16-cycle count from that request.
- R5: `cause_o` bit 0 flags a power-fail reset, bit 1 an external reset and bit 2 a watchdog reset. Every source active during a reset gets its flag set, including several sources at once.
- R6: The flags of sources that were not active keep their values, and no reset clears any flag.
- R7: A clock edge with `cause_clr_we_i` = 1 clears each flag whose bit in `cause_clr_i` is 1 and leaves the other flags unchanged.
- R8: If a source is active in the same cycle that its flag is being cleared, the flag ends up set.
- R9: While any request is active, and while `sys_rst_n_o` is low, the pads take their safe levels at once. Port p uses bits [p*8 +: 8] and enable bit p. Port 0 has output enable 0 and data 00h. Ports 1 to 5 have output enable 1 and data FFh. The flash data bus has enable 0 and data 00h. Write-protect is driven 0 and chip-enable is driven 1.
- R10: Out of reset, every pad output equals its functional input.
- R11: `reset_vec_o` is 0000h.
- R12: A low pulse on `ext_rst_n_i` shorter than one clock period still produces the full reset of R2 and sets flag bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| pwr_fail_i | input | 1 | Brown-out detector output, active high, asynchronous |
| wdt_timeout_i | input | 1 | Watchdog timeout pulse, synchronous |
| cause_clr_we_i | input | 1 | Write strobe for clearing cause flags |
| cause_clr_i | input | 3 | Clear mask, a 1 clears that flag |
| func_port_out_i | input | 48 | Functional data for the six 8-bit ports |
| func_port_oe_i | input | 6 | Functional output enable per port |
| func_fd_out_i | input | 8 | Functional flash data bus value |
| func_fd_oe_i | input | 1 | Functional flash data bus enable |
| func_wp_i | input | 1 | Functional flash write-protect level |
| func_ce_i | input | 1 | Functional flash chip-enable level |
| sys_rst_n_o | output | 1 | System reset to core and peripherals, active low |
| reset_vec_o | output | 16 | Start address for the core after reset |
| cause_o | output | 3 | Sticky reset cause flags |
| pad_port_out_o | output | 48 | Port data to the pads |
| pad_port_oe_o | output | 6 | Port output enables to the pads |
| pad_fd_out_o | output | 8 | Flash data bus to the pads |
| pad_fd_oe_o | output | 1 | Flash data bus enable to the pads |
| pad_wp_o | output | 1 | Flash write-protect line to the pad |
| pad_ce_o | output | 1 | Flash chip-enable line to the pad |

## Verification
The hardest case to reach from the ports is an external pulse that starts and ends between two clock edges. No edge ever sees the pin low, so the only evidence of the pulse is the cleared synchronizer. The bench drops and raises the pin one nanosecond apart in the middle of a cycle. It then checks both the full-length reset and the external flag. A second hard case is a flag being set and cleared in the same cycle. The bench issues a clear strobe in the same cycle as a watchdog pulse, and separately sends a second watchdog pulse part-way through the hold window to show that the count restarts.

// File: rtl/rstctl_pkg.sv
`timescale 1ns/1ps
package rstctl_pkg;
    localparam int unsigned CAUSE_N   = 3;
    localparam int unsigned CAUSE_PFD = 0;
    localparam int unsigned CAUSE_EXT = 1;
    localparam int unsigned CAUSE_WDT = 2;
    // sources that assert asynchronously share the cause indices 0 and 1
    localparam int unsigned ASYNC_N   = 2;

    typedef logic [CAUSE_N-1:0] cause_vec_t;
endpackage

// File: rtl/rstctl_sync.sv
`timescale 1ns/1ps
module rstctl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic req_n_i,
    output logic ok_o
);
    localparam int unsigned W = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [W-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[W-2:0], 1'b1};
    end

    always_ff @(posedge clk_i or negedge req_n_i) begin
        if (!req_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign ok_o = st_q.sh[W-1];
endmodule

// File: rtl/rstctl_stretch.sv
`timescale 1ns/1ps
module rstctl_stretch #(
    parameter int unsigned HOLD = 16
) (
    input  logic clk_i,
    input  logic arst_n_i,
    input  logic src_ok_i,
    input  logic kick_i,
    output logic active_o
);
    localparam int unsigned HOLD_E = (HOLD < 1) ? 1 : HOLD;
    localparam int unsigned CNT_W  = $clog2(HOLD_E + 1);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_E);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
    } str_st_t;

    str_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!src_ok_i || kick_i) begin
            st_d.cnt    = HOLD_C;
            st_d.active = 1'b1;
        end else if (st_q.cnt != '0) begin
            st_d.cnt    = st_q.cnt - ONE_C;
            st_d.active = (st_q.cnt != ONE_C);
        end
    end

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            st_q.cnt    <= HOLD_C;
            st_q.active <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
endmodule

// File: rtl/rstctl_cause.sv
`timescale 1ns/1ps
module rstctl_cause
    import rstctl_pkg::*;
(
    input  logic       clk_i,
    input  cause_vec_t set_i,
    input  logic       clr_we_i,
    input  cause_vec_t clr_mask_i,
    output cause_vec_t flags_o
);
    typedef struct packed {
        cause_vec_t flags;
    } cause_st_t;

    cause_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i) st_d.flags = st_d.flags & ~clr_mask_i;
        st_d.flags = st_d.flags | set_i;   // setting wins over clearing
    end

    // no reset on purpose: the flags must outlive every reset
    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/rstctl_pad.sv
`timescale 1ns/1ps
module rstctl_pad #(
    parameter int unsigned PORTS  = 6,
    parameter int unsigned PORT_W = 8,
    parameter int unsigned FD_W   = 8
) (
    input  logic                    force_i,
    input  logic [PORTS*PORT_W-1:0] func_port_out_i,
    input  logic [PORTS-1:0]        func_port_oe_i,
    input  logic [FD_W-1:0]         func_fd_out_i,
    input  logic                    func_fd_oe_i,
    input  logic                    func_wp_i,
    input  logic                    func_ce_i,
    output logic [PORTS*PORT_W-1:0] pad_port_out_o,
    output logic [PORTS-1:0]        pad_port_oe_o,
    output logic [FD_W-1:0]         pad_fd_out_o,
    output logic                    pad_fd_oe_o,
    output logic                    pad_wp_o,
    output logic                    pad_ce_o
);
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        // port 0 floats in reset, every other port drives all ones
        localparam logic SAFE_DRV = (p != 0);
        assign pad_port_out_o[p*PORT_W +: PORT_W] =
            force_i ? {PORT_W{SAFE_DRV}} : func_port_out_i[p*PORT_W +: PORT_W];
        assign pad_port_oe_o[p] = force_i ? SAFE_DRV : func_port_oe_i[p];
    end

    assign pad_fd_out_o = force_i ? '0   : func_fd_out_i;
    assign pad_fd_oe_o  = force_i ? 1'b0 : func_fd_oe_i;
    assign pad_wp_o     = force_i ? 1'b0 : func_wp_i;
    assign pad_ce_o     = force_i ? 1'b1 : func_ce_i;
endmodule

// File: rtl/rstctl_top.sv
`timescale 1ns/1ps
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PORTS       = 6,
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned FD_W        = 8,
    parameter int unsigned VEC_W       = 16,
    parameter logic [VEC_W-1:0] RESET_VEC = '0
) (
    input  logic                    clk_i,
    input  logic                    ext_rst_n_i,
    input  logic                    pwr_fail_i,
    input  logic                    wdt_timeout_i,
    input  logic                    cause_clr_we_i,
    input  logic [2:0]              cause_clr_i,
    input  logic [PORTS*PORT_W-1:0] func_port_out_i,
    input  logic [PORTS-1:0]        func_port_oe_i,
    input  logic [FD_W-1:0]         func_fd_out_i,
    input  logic                    func_fd_oe_i,
    input  logic                    func_wp_i,
    input  logic                    func_ce_i,
    output logic                    sys_rst_n_o,
    output logic [VEC_W-1:0]        reset_vec_o,
    output logic [2:0]              cause_o,
    output logic [PORTS*PORT_W-1:0] pad_port_out_o,
    output logic [PORTS-1:0]        pad_port_oe_o,
    output logic [FD_W-1:0]         pad_fd_out_o,
    output logic                    pad_fd_oe_o,
    output logic                    pad_wp_o,
    output logic                    pad_ce_o
);
    logic [ASYNC_N-1:0] req_n;
    logic [ASYNC_N-1:0] src_ok;
    logic               all_ok;
    logic               arst_n;
    logic               hold_active;
    logic               pad_force;
    cause_vec_t         cause_set;
    cause_vec_t         cause_flags;

    assign req_n[CAUSE_PFD] = ~pwr_fail_i;
    assign req_n[CAUSE_EXT] = ext_rst_n_i;
    assign arst_n           = &req_n;

    for (genvar s = 0; s < ASYNC_N; s++) begin : g_sync
        rstctl_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk_i   (clk_i),
            .req_n_i (req_n[s]),
            .ok_o    (src_ok[s])
        );
        assign cause_set[s] = ~src_ok[s];
    end
    assign cause_set[CAUSE_WDT] = wdt_timeout_i;
    assign all_ok               = &src_ok;

    rstctl_stretch #(.HOLD(HOLD_CYCLES)) i_stretch (
        .clk_i    (clk_i),
        .arst_n_i (arst_n),
        .src_ok_i (all_ok),
        .kick_i   (wdt_timeout_i),
        .active_o (hold_active)
    );

    rstctl_cause i_cause (
        .clk_i      (clk_i),
        .set_i      (cause_set),
        .clr_we_i   (cause_clr_we_i),
        .clr_mask_i (cause_clr_i),
        .flags_o    (cause_flags)
    );

    assign pad_force = ~arst_n | wdt_timeout_i | hold_active;

    rstctl_pad #(.PORTS(PORTS), .PORT_W(PORT_W), .FD_W(FD_W)) i_pad (
        .force_i         (pad_force),
        .func_port_out_i (func_port_out_i),
        .func_port_oe_i  (func_port_oe_i),
        .func_fd_out_i   (func_fd_out_i),
        .func_fd_oe_i    (func_fd_oe_i),
        .func_wp_i       (func_wp_i),
        .func_ce_i       (func_ce_i),
        .pad_port_out_o  (pad_port_out_o),
        .pad_port_oe_o   (pad_port_oe_o),
        .pad_fd_out_o    (pad_fd_out_o),
        .pad_fd_oe_o     (pad_fd_oe_o),
        .pad_wp_o        (pad_wp_o),
        .pad_ce_o        (pad_ce_o)
    );

    assign sys_rst_n_o = ~hold_active;
    assign reset_vec_o = RESET_VEC;
    assign cause_o     = cause_flags;
endmodule

// File: rtl/rstctl_chk.sv
`timescale 1ns/1ps
module rstctl_chk (
    input logic       clk_i,
    input logic       ext_rst_n_i,
    input logic       pwr_fail_i,
    input logic       wdt_timeout_i,
    input logic       cause_clr_we_i,
    input logic [2:0] cause_clr_i,
    input logic       sys_rst_n_o,
    input logic [2:0] cause_o,
    input logic       port0_oe_i,
    input logic       pad_fd_oe_o,
    input logic       pad_wp_o,
    input logic       pad_ce_o
);
    logic quiet;
    assign quiet = ext_rst_n_i && !pwr_fail_i;

    AST_WDT_RESETS: assert property (@(posedge clk_i) disable iff (!quiet)
        wdt_timeout_i |=> !sys_rst_n_o);                                     // R3

    AST_WDT_FLAG: assert property (@(posedge clk_i) disable iff (!quiet)
        wdt_timeout_i |=> cause_o[2]);                                       // R5

    AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!quiet)
        !cause_clr_we_i |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R6

    AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!quiet)
        (cause_clr_we_i && !wdt_timeout_i && sys_rst_n_o)
        |=> ((cause_o & $past(cause_clr_i)) == 3'b000));                     // R7

    AST_PADS_SAFE: assert property (@(posedge clk_i) disable iff (!quiet)
        !sys_rst_n_o |-> (!pad_wp_o && pad_ce_o && !pad_fd_oe_o && !port0_oe_i)); // R9

    AST_RELEASE_IDLE: assert property (@(posedge clk_i) disable iff (!quiet)
        $rose(sys_rst_n_o) |-> !$past(wdt_timeout_i));                       // R2
endmodule

bind rstctl_top rstctl_chk i_chk (
    .clk_i          (clk_i),
    .ext_rst_n_i    (ext_rst_n_i),
    .pwr_fail_i     (pwr_fail_i),
    .wdt_timeout_i  (wdt_timeout_i),
    .cause_clr_we_i (cause_clr_we_i),
    .cause_clr_i    (cause_clr_i),
    .sys_rst_n_o    (sys_rst_n_o),
    .cause_o        (cause_o),
    .port0_oe_i     (pad_port_oe_o[0]),
    .pad_fd_oe_o    (pad_fd_oe_o),
    .pad_wp_o       (pad_wp_o),
    .pad_ce_o       (pad_ce_o)
);

// File: tb/test_rstctl_top.sv
`timescale 1ns/1ps
module test_rstctl_top;
    localparam int PORTS = 6, PORT_W = 8, FD_W = 8, VEC_W = 16;
    localparam logic [47:0] SAFE_OUT = {{5{8'hFF}}, 8'h00};
    localparam logic [5:0]  SAFE_OE  = 6'b111110;
    localparam logic [47:0] F_OUT    = 48'h1234_5678_9ABC;
    localparam logic [5:0]  F_OE     = 6'b010101;

    // [6] clear first, [5] ext, [4] pfd, [3] wdt, [2:0] expected flags
    localparam logic [6:0] VECS [8] = '{
        7'b1_1_0_0_010, 7'b0_0_0_1_110, 7'b1_0_1_0_001, 7'b1_1_1_0_011,
        7'b0_0_0_1_111, 7'b1_1_1_1_111, 7'b1_0_0_1_100, 7'b0_0_1_0_101 };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic ext_n = 1'b0, pfd = 1'b0, wdt = 1'b0, clr_we = 1'b0;
    logic [2:0] clr = 3'b000;
    logic [47:0] f_out = F_OUT;
    logic [5:0]  f_oe = F_OE;
    logic [7:0]  f_fd = 8'h5A;
    logic f_fd_oe = 1'b1, f_wp = 1'b1, f_ce = 1'b0;

    logic sys_rst_n;
    logic [VEC_W-1:0] rvec;
    logic [2:0] cause;
    logic [47:0] p_out;
    logic [5:0]  p_oe;
    logic [7:0]  p_fd;
    logic p_fd_oe, p_wp, p_ce;

    rstctl_top i_rstctl_top (
        .clk_i(clk), .ext_rst_n_i(ext_n), .pwr_fail_i(pfd), .wdt_timeout_i(wdt),
        .cause_clr_we_i(clr_we), .cause_clr_i(clr),
        .func_port_out_i(f_out), .func_port_oe_i(f_oe), .func_fd_out_i(f_fd),
        .func_fd_oe_i(f_fd_oe), .func_wp_i(f_wp), .func_ce_i(f_ce),
        .sys_rst_n_o(sys_rst_n), .reset_vec_o(rvec), .cause_o(cause),
        .pad_port_out_o(p_out), .pad_port_oe_o(p_oe), .pad_fd_out_o(p_fd),
        .pad_fd_oe_o(p_fd_oe), .pad_wp_o(p_wp), .pad_ce_o(p_ce)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_safe(input string req);
        chk(req, 64'(p_out), 64'(SAFE_OUT));
        chk(req, 64'(p_oe), 64'(SAFE_OE));
        chk(req, 64'({p_fd, p_fd_oe, p_wp, p_ce}), 64'({8'h00, 1'b0, 1'b0, 1'b1}));
    endtask

    task automatic clear_flags(input logic [2:0] m);
        clr_we = 1'b1; clr = m;
        step(1);
        clr_we = 1'b0; clr = 3'b000;
    endtask

    initial begin
        // reset state while the pin is low (R1, R9, R11)
        step(1);
        chk("R1 reset low", 64'(sys_rst_n), 64'd0);
        check_safe("R9 reset pads");
        chk("R11 vector", 64'(rvec), 64'h0000);
        // release timing (R2)
        ext_n = 1'b1;
        step(17);
        chk("R2 still held", 64'(sys_rst_n), 64'd0);
        step(1);
        chk("R2 released", 64'(sys_rst_n), 64'd1);
        chk("R10 pads functional", 64'(p_out), 64'(F_OUT));
        chk("R10 oe functional", 64'(p_oe), 64'(F_OE));
        chk("R10 flash functional", 64'({p_fd, p_fd_oe, p_wp, p_ce}), 64'({8'h5A, 1'b1, 1'b1, 1'b0}));
        clear_flags(3'b111);
        chk("R7 clear all", 64'(cause), 64'd0);

        // table of source combinations (R5, R6)
        for (int i = 0; i < 8; i++) begin
            logic [6:0] v;
            v = VECS[i];
            if (v[6]) clear_flags(3'b111);
            ext_n = !v[5]; pfd = v[4]; wdt = v[3];
            step(1);
            wdt = 1'b0;
            chk("R1 source asserts", 64'(sys_rst_n), 64'd0);
            step(2);
            ext_n = 1'b1; pfd = 1'b0;
            step(25);
            chk("R5 R6 cause flags", 64'(cause), 64'(v[2:0]));
            chk("R1 released after vector", 64'(sys_rst_n), 64'd1);
        end

        // immediate pad forcing by power fail (R9, R1)
        clear_flags(3'b111);
        pfd = 1'b1;
        #1;
        check_safe("R9 immediate on pfd");
        chk("R1 async pfd", 64'(sys_rst_n), 64'd0);
        step(2);
        pfd = 1'b0;
        step(17);
        chk("R2 pfd held", 64'(sys_rst_n), 64'd0);
        step(1);
        chk("R2 pfd released", 64'(sys_rst_n), 64'd1);
        chk("R5 pfd flag", 64'(cause), 64'b001);

        // watchdog window (R3)
        wdt = 1'b1;
        #1;
        check_safe("R9 immediate on wdt");
        step(1);
        wdt = 1'b0;
        chk("R3 wdt low", 64'(sys_rst_n), 64'd0);
        step(15);
        chk("R3 wdt last low", 64'(sys_rst_n), 64'd0);
        step(1);
        chk("R3 wdt released", 64'(sys_rst_n), 64'd1);
        chk("R6 pfd flag kept", 64'(cause), 64'b101);

        // partial clear (R7)
        clear_flags(3'b001);
        chk("R7 partial clear", 64'(cause), 64'b100);

        // set wins over clear (R8)
        wdt = 1'b1; clr_we = 1'b1; clr = 3'b100;
        step(1);
        wdt = 1'b0; clr_we = 1'b0; clr = 3'b000;
        chk("R8 set wins", 64'(cause), 64'b100);
        step(17);
        clear_flags(3'b100);
        chk("R7 clear wdt", 64'(cause), 64'b000);

        // restart during hold (R4)
        wdt = 1'b1; step(1); wdt = 1'b0;
        step(7);
        wdt = 1'b1; step(1); wdt = 1'b0;
        step(15);
        chk("R4 restarted hold", 64'(sys_rst_n), 64'd0);
        step(1);
        chk("R4 released", 64'(sys_rst_n), 64'd1);
        clear_flags(3'b111);

        // sub-cycle pin glitch (R12)
        ext_n = 1'b0;
        #1;
        ext_n = 1'b1;
        step(17);
        chk("R12 glitch held", 64'(sys_rst_n), 64'd0);
        step(1);
        chk("R12 glitch released", 64'(sys_rst_n), 64'd1);
        chk("R12 glitch flag", 64'(cause), 64'b010);
        chk("R11 vector after", 64'(rvec), 64'h0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule